// File: doc/BRIEF.md
# TFT Panel Control Output Stage

This block sits between a display timing generator and a high-resolution TFT panel. It produces the panel's three auxiliary control lines, a free-running shift clock and the registered 12-bit pixel data bus. A 4-bit configuration register, written and read over a simple bus port, sets how these outputs behave. The register bits choose between a control line that flips on every line and a programmed pulse, enable or force low all auxiliary lines, select the shift clock edge on which pixel data is launched, and exchange the two pulse-type control lines.

A per-line pixel counter is cleared by each line pulse and advances on every pixel enable. Two window comparators turn programmed start and width values into a start-of-line pulse (function "PS") and a clock-select pulse (function "CLS"). The third line ("REV") copies a level input. All control outputs leave the block through registers, so a configuration write in the middle of a line cannot cause a glitch. The register must stay at zero for panels of other kinds.

Top module: `tft_ctl_out`

## Requirements
- R1: After reset the configuration register reads 0. A read returns the register in bits 3..0 (bit 3 = CLS mode, bit 2 = programmed enable, bit 1 = launch edge, bit 0 = swap), and bits 31..4 always read 0 whatever was written.
- R2: While bit 2 is 0, ctl0, ctl1 and ctl2 are all 0.
- R3: While bit 3 is 0, the CLS function inverts its level once for every line pulse.
- R4: While bit 3 is 1, the CLS function is 1 exactly while the pixel count c satisfies cls_start <= c < cls_start + cls_width.
- R5: The PS function is 1 exactly while ps_start <= c < ps_start + ps_width. A width of 0 gives no pulse. The count is 0 after a line pulse and rises by 1 per pixel enable.
- R6: With bit 0 = 0, ctl0 carries PS and ctl1 carries CLS. With bit 0 = 1 the two are exchanged.
- R7: While bit 2 is 1, ctl2 follows rev_level.
- R8: shift_clk inverts on every clock cycle. With bit 1 = 0, pix_out loads pix_in only on the edge that drives shift_clk low. With bit 1 = 1, it loads only on the edge that drives shift_clk high, and only when pix_en is 1.
- R9: The CLS toggle resets to 0 at reset and whenever a write changes bit 3. This clear takes priority over a line pulse in the same cycle.
- R10: ctl0..ctl2 are registered: they reflect the count, toggle and configuration one clock after those values are present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| line_pulse | input | 1 | One-cycle line pulse from timing generator |
| pix_en | input | 1 | Pixel clock enable |
| ps_start | input | 8 | PS pulse start count |
| ps_width | input | 8 | PS pulse width in pixels |
| cls_start | input | 8 | CLS pulse start count |
| cls_width | input | 8 | CLS pulse width in pixels |
| rev_level | input | 1 | Level driven on ctl2 when enabled |
| pix_in | input | 12 | Pixel data in |
| ctl0 | output | 1 | Control line 0 |
| ctl1 | output | 1 | Control line 1 |
| ctl2 | output | 1 | Control line 2 |
| shift_clk | output | 1 | Panel shift clock |
| pix_out | output | 12 | Registered pixel data out |

## Verification
A line pulse and a configuration write that flips the CLS mode bit can land in the same clock cycle. The first would invert the toggle and the second clears it. The bench provokes this by asserting line_pulse during the write that moves bit 3 from 1 to 0. It judges the outcome at ctl1 one clock later, where it must read 0, and then checks that a following lone line pulse drives ctl1 to 1.

// File: rtl/tft_ctl_pkg.sv
// Package: shared configuration type for the TFT control output stage.
// Assumes the register field order below is the software-visible bit order.
package tft_ctl_pkg;
    localparam int CFG_W = 4;

    typedef struct packed {
        logic cls_prog;   // bit 3: CLS from programmed window
        logic prog_en;    // bit 2: enable control outputs
        logic sclk_fall;  // bit 1: launch data on rising shift clock
        logic swap;       // bit 0: exchange ctl0 and ctl1
    } tft_cfg_t;
endpackage

// File: rtl/tft_line_cnt.sv
// Module: per-line pixel counter. Clears on a line pulse, advances on each
// pixel enable and saturates at its maximum so a window cannot re-trigger.
// Assumes line_pulse is a single-cycle strobe.
module tft_line_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_pulse,
    input  logic             pix_en,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Count pixels within the current line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (line_pulse) begin
            cnt <= '0;
        end else if (pix_en && (cnt != CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tft_pulse_win.sv
// Module: window comparator. Active while start <= cnt < start + width.
// Assumes unsigned values; a zero width never activates.
module tft_pulse_win #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] start,
    input  logic [CNT_W-1:0] width,
    output logic             active
);
    logic [CNT_W-1:0] offset;

    // Distance past the start point, only meaningful when cnt >= start.
    always_comb begin
        offset = cnt - start;
        active = (cnt >= start) && (offset < width);
    end
endmodule

// File: rtl/tft_cls_toggle.sv
// Module: per-line toggle flip-flop for the CLS function. Inverts on each
// line pulse; a mode change clears it and takes priority over the pulse.
module tft_cls_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic line_pulse,
    input  logic mode_chg,
    output logic tog
);
    // Toggle per line, cleared on mode change.
    always_ff @(posedge clk) begin
        if (!rst_n || mode_chg) begin
            tog <= 1'b0;
        end else if (line_pulse) begin
            tog <= ~tog;
        end
    end

    AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (line_pulse && !mode_chg) |=> (tog != $past(tog)));  // R3
    AST_TOG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> !tog);  // R9
endmodule

// File: rtl/tft_shift_stage.sv
// Module: shift clock at half the clock rate plus registered pixel data
// launched on the shift clock edge chosen by fall_sel.
// Assumes pix_in is stable for at least two clocks per pixel.
module tft_shift_stage #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_en,
    input  logic              fall_sel,
    input  logic [DATA_W-1:0] pix_in,
    output logic              shift_clk,
    output logic [DATA_W-1:0] pix_out
);
    logic launch;

    // Launch when the next shift clock level equals the selected level.
    always_comb launch = pix_en && ((!shift_clk) == fall_sel);

    // Free-running shift clock and data launch register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_clk <= 1'b0;
            pix_out   <= '0;
        end else begin
            shift_clk <= ~shift_clk;
            if (launch) begin
                pix_out <= pix_in;
            end
        end
    end

    AST_SCLK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (shift_clk != $past(shift_clk)));  // R8
    AST_LAUNCH_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pix_out) |-> (shift_clk == $past(fall_sel)));  // R8
endmodule

// File: rtl/tft_ctl_out.sv
// Module: TFT panel control output stage (top). Holds the 4-bit
// configuration register, builds PS/CLS/REV functions, gates, swaps and
// registers them, and drives the shift clock and pixel data.
// Assumes line_pulse and pix_en come from the same clock domain.
module tft_ctl_out
    import tft_ctl_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int CNT_W  = 8,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [BUS_W-1:0]  cfg_wdata,
    output logic [BUS_W-1:0]  cfg_rdata,
    input  logic              line_pulse,
    input  logic              pix_en,
    input  logic [CNT_W-1:0]  ps_start,
    input  logic [CNT_W-1:0]  ps_width,
    input  logic [CNT_W-1:0]  cls_start,
    input  logic [CNT_W-1:0]  cls_width,
    input  logic              rev_level,
    input  logic [DATA_W-1:0] pix_in,
    output logic              ctl0,
    output logic              ctl1,
    output logic              ctl2,
    output logic              shift_clk,
    output logic [DATA_W-1:0] pix_out
);
    localparam int NWIN  = 2;   // window 0 = PS, window 1 = CLS
    localparam int PAD_W = BUS_W - CFG_W;

    tft_cfg_t           cfg_q;
    logic               mode_chg;
    logic               tog;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   win_start [NWIN];
    logic [CNT_W-1:0]   win_width [NWIN];
    logic [NWIN-1:0]    win_act;
    logic               ps_fn;
    logic               cls_fn;
    logic               unused_wdata_hi;

    // Upper write bits carry no state.
    assign unused_wdata_hi = ^cfg_wdata[BUS_W-1:CFG_W];

    // Configuration register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q <= tft_cfg_t'(cfg_wdata[CFG_W-1:0]);
        end
    end

    // Read path: live bits low, zero above.
    assign cfg_rdata = {{PAD_W{1'b0}}, cfg_q};

    // A write that flips the CLS mode bit clears the toggle.
    assign mode_chg = cfg_we && (cfg_wdata[CFG_W-1] != cfg_q.cls_prog);

    tft_line_cnt #(.CNT_W(CNT_W)) i_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_pulse (line_pulse),
        .pix_en     (pix_en),
        .cnt        (cnt)
    );

    // Window settings: PS first, CLS second.
    always_comb begin
        win_start[0] = ps_start;
        win_width[0] = ps_width;
        win_start[1] = cls_start;
        win_width[1] = cls_width;
    end

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        tft_pulse_win #(.CNT_W(CNT_W)) i_win (
            .cnt    (cnt),
            .start  (win_start[g]),
            .width  (win_width[g]),
            .active (win_act[g])
        );
    end

    tft_cls_toggle i_tog (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_pulse (line_pulse),
        .mode_chg   (mode_chg),
        .tog        (tog)
    );

    // Select CLS source and PS function.
    always_comb begin
        ps_fn  = win_act[0];
        cls_fn = cfg_q.cls_prog ? win_act[1] : tog;
    end

    // Registered, gated and optionally swapped control outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl0 <= 1'b0;
            ctl1 <= 1'b0;
            ctl2 <= 1'b0;
        end else begin
            ctl0 <= cfg_q.prog_en && (cfg_q.swap ? cls_fn : ps_fn);
            ctl1 <= cfg_q.prog_en && (cfg_q.swap ? ps_fn : cls_fn);
            ctl2 <= cfg_q.prog_en && rev_level;
        end
    end

    tft_shift_stage #(.DATA_W(DATA_W)) i_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_en    (pix_en),
        .fall_sel  (cfg_q.sclk_fall),
        .pix_in    (pix_in),
        .shift_clk (shift_clk),
        .pix_out   (pix_out)
    );

    AST_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.prog_en |=> !(ctl0 || ctl1 || ctl2));  // R2
    AST_REV_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.prog_en |=> (ctl2 == $past(rev_level)));  // R7
endmodule

// File: tb/test_tft_ctl_out.sv
// Bench: table-driven window/gate/swap checks, then directed tests for
// reset, readback, per-line toggle, mode-change clear and launch edge.
module test_tft_ctl_out;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        line_pulse = 1'b0;
    logic        pix_en = 1'b1;
    logic [7:0]  ps_start = 8'd3, ps_width = 8'd2;
    logic [7:0]  cls_start = 8'd5, cls_width = 8'd3;
    logic        rev_level = 1'b0;
    logic [11:0] pix_in = '0;
    logic        ctl0, ctl1, ctl2, shift_clk;
    logic [11:0] pix_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    tft_ctl_out i_tft_ctl_out (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .line_pulse(line_pulse), .pix_en(pix_en),
        .ps_start(ps_start), .ps_width(ps_width), .cls_start(cls_start),
        .cls_width(cls_width), .rev_level(rev_level), .pix_in(pix_in),
        .ctl0(ctl0), .ctl1(ctl1), .ctl2(ctl2), .shift_clk(shift_clk),
        .pix_out(pix_out)
    );

    // Vector: {cfg[3:0], count[7:0], rev, expected {ctl2,ctl1,ctl0}}
    // PS window counts 3..4, CLS window counts 5..7.
    localparam int NVEC = 11;
    localparam logic [15:0] VEC [NVEC] = '{
        {4'hC, 8'd3, 1'b1, 3'b101},   // R5 R7
        {4'hC, 8'd5, 1'b1, 3'b110},   // R4
        {4'hC, 8'd2, 1'b0, 3'b000},   // R5 before start
        {4'hC, 8'd7, 1'b0, 3'b010},   // R4 last pixel
        {4'hC, 8'd8, 1'b1, 3'b100},   // R4 past end
        {4'hD, 8'd3, 1'b0, 3'b010},   // R6 PS on ctl1
        {4'hD, 8'd6, 1'b0, 3'b001},   // R6 CLS on ctl0
        {4'hD, 8'd4, 1'b1, 3'b110},   // R6
        {4'h8, 8'd3, 1'b1, 3'b000},   // R2 gated
        {4'h8, 8'd5, 1'b1, 3'b000},   // R2 gated
        {4'hE, 8'd4, 1'b0, 3'b001}    // R5 edge select ignored
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp,
                         input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [31:0] v, input logic with_line);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v; line_pulse = with_line;
        @(negedge clk);
        cfg_we = 1'b0; line_pulse = 1'b0;
    endtask

    // Line pulse, then wait until outputs reflect pixel count k.
    task automatic line_to(input int k);
        @(negedge clk);
        line_pulse = 1'b1;
        @(negedge clk);
        line_pulse = 1'b0;
        repeat (k + 1) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic launch_run(input logic pol, input string req);
        logic        prev_sclk;
        logic [11:0] prev_out, prev_in;
        prev_sclk = shift_clk; prev_out = pix_out;
        pix_in = 12'h5A3; prev_in = pix_in;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            check({31'd0, shift_clk}, {31'd0, ~prev_sclk}, req);
            check({20'd0, pix_out},
                  {20'd0, (shift_clk == pol) ? prev_in : prev_out}, req);
            prev_sclk = shift_clk; prev_out = pix_out;
            pix_in = pix_in + 12'd37; prev_in = pix_in;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 / reset state
        check(cfg_rdata, 32'h0, "R1 reset read");
        check({29'd0, ctl2, ctl1, ctl0}, 32'h0, "R10 reset ctl");
        check({19'd0, shift_clk, pix_out}, 32'h0, "R8 reset shift");
        rst_n = 1'b1;

        cfg_write(32'hFFFF_FFFF, 1'b0);
        check(cfg_rdata, 32'h0000_000F, "R1 upper bits read zero");

        // Table walk: R2 R4 R5 R6 R7
        for (int v = 0; v < NVEC; v++) begin
            cfg_write({28'd0, VEC[v][15:12]}, 1'b0);
            rev_level = VEC[v][3];
            line_to(int'(VEC[v][11:4]));
            check({29'd0, ctl2, ctl1, ctl0}, {29'd0, VEC[v][2:0]},
                  $sformatf("R2/R4/R5/R6/R7 vector %0d", v));
        end
        rev_level = 1'b0;

        // R5: zero width never pulses
        ps_width = 8'd0;
        cfg_write(32'hC, 1'b0);
        line_to(3);
        check({31'd0, ctl0}, 32'd0, "R5 zero width");
        ps_width = 8'd2;

        // R3: per-line toggle (bit 3 moves 1->0 here, toggle cleared)
        cfg_write(32'h4, 1'b0);
        line_to(0);
        check({31'd0, ctl1}, 32'd1, "R3 first line");
        line_to(0);
        check({31'd0, ctl1}, 32'd0, "R3 second line");
        line_to(0);
        check({31'd0, ctl1}, 32'd1, "R3 third line");
        // R6 swap of toggle onto ctl0
        cfg_write(32'h5, 1'b0);
        @(posedge clk); @(negedge clk);
        check({31'd0, ctl0}, 32'd1, "R6 toggle swapped to ctl0");

        // R9: mode change with coincident line pulse clears toggle
        cfg_write(32'hD, 1'b0);
        cfg_write(32'h4, 1'b1);
        @(posedge clk); @(negedge clk);
        check({31'd0, ctl1}, 32'd0, "R9 clear beats line pulse");
        line_to(0);
        check({31'd0, ctl1}, 32'd1, "R9 toggle after clear");

        // R8: launch edge for both settings
        cfg_write(32'h4, 1'b0);
        launch_run(1'b0, "R8 launch on falling");
        cfg_write(32'h6, 1'b0);
        launch_run(1'b1, "R8 launch on rising");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule